// File: doc/BRIEF.md
# Imaging Front-End Pixel Byte Reassembler

This block sits behind the 8-bit output bus of a 14-bit imaging converter. It rebuilds every 14-bit result from two bus bytes and labels it with its colour channel. The converter sends each result over one converter clock period. The high byte travels in the half where the converter clock is high, and the low byte follows in the half where it is low. Capture is synchronous: `clk_i` runs once per byte phase, and `phase_i` carries the converter clock level. A byte is taken only while the bus output enable `oe_i` is asserted.

The converter's output trails its analog samples by three results. The channel label therefore passes through a matching three-deep pipeline before it reaches `chan_o`. In three-channel mode the label steps through a programmable order of three slots. In one-channel mode every result carries a fixed channel. A start-of-line marker restarts the channel sequence and empties the label pipeline. The first three results after the marker are then suppressed.

Top module: `pix_reasm`

## Requirements
- R1: A completed result on `sample_o` has bits 13..6 equal to the bus byte captured with `phase_i`=1, and bits 5..0 equal to bits 7..2 of the bus byte captured with `phase_i`=0.
- R2: Bus bits 1..0 of the low byte have no effect on `sample_o`.
- R3: A high byte is captured on an edge with `oe_i`=1 and `phase_i`=1. A low byte completes a result only if a high byte is pending. A low byte without a pending high byte produces no `valid_o`, and `sample_o` does not change.
- R4: `valid_o` is high for exactly the one cycle after the edge that captured the completing low byte. `sample_o` and `chan_o` change only together with `valid_o`.
- R5: On edges with `oe_i`=0 no byte is captured. A pending high byte is kept, and `valid_o` stays low with `sample_o` unchanged.
- R6: With `mode_i`=1 (three-channel), the channel sequence runs through slot 0, slot 1 and slot 2 of `order_i` and then repeats. Slot i occupies bits 2i+1..2i. The channel codes are 0 red, 1 green and 2 blue.
- R7: With `mode_i`=0 (one-channel), every result is tagged with `fixed_ch_i`, and `order_i` has no effect.
- R8: The tag on a valid result is the channel assigned to the result three completions earlier in the same line.
- R9: `sol_i`=1 on an edge restarts the sequence at slot 0 and clears the tag pipeline. The first three results completed after it do not raise `valid_o`. The fourth does.
- R10: If `sol_i` is high on the edge of a low byte, that low byte and any pending high byte are discarded, and no `valid_o` follows.
- R11: After reset `valid_o`=0, `sample_o`=0, `chan_o`=0, and the first three results are suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte-rate clock, one edge per bus byte |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Converter output bus |
| phase_i | input | 1 | Converter clock level: 1 high-byte half, 0 low-byte half |
| oe_i | input | 1 | Bus output enable; bytes ignored when 0 |
| sol_i | input | 1 | Start-of-line marker |
| mode_i | input | 1 | 1 three-channel, 0 one-channel |
| order_i | input | 6 | Three 2-bit channel slots for three-channel mode |
| fixed_ch_i | input | 2 | Channel used in one-channel mode |
| sample_o | output | 14 | Reassembled result |
| chan_o | output | 2 | Channel tag of `sample_o` |
| valid_o | output | 1 | One-cycle strobe for a new tagged result |

## Verification
The start-of-line marker can arrive on the same edge as the low byte that would complete a result. When it does, the restart must win: the half-built result is dropped, and counting toward the three suppressed results starts from that edge. The bench provokes this by driving a high byte and then raising the marker together with the low byte. It expects no strobe on that edge, no strobe for the next three complete pixels, and a correctly tagged strobe on the fourth. A second overlap is an output-enable gap between the two bytes of one pixel. The result must join the held high byte with the low byte sent after the gap, ignoring the bus values driven while the enable was low.

// File: rtl/pix_reasm_pkg.sv
package pix_reasm_pkg;
  typedef enum logic {
    MODE_ONE   = 1'b0,
    MODE_THREE = 1'b1
  } ch_mode_e;

  localparam int unsigned CH_RED   = 0;
  localparam int unsigned CH_GREEN = 1;
  localparam int unsigned CH_BLUE  = 2;
endpackage

// File: rtl/pix_byte_join.sv
module pix_byte_join #(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BUS_W-1:0]    data_i,
  input  logic                phase_i,
  input  logic                oe_i,
  input  logic                sol_i,
  output logic                done_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int unsigned LO_W = SAMPLE_W - BUS_W;

  logic [BUS_W-1:0] hi_q;
  logic             pend_q;
  logic             cap_hi, take_lo;

  assign cap_hi  = oe_i && phase_i;
  assign take_lo = oe_i && !phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else if (cap_hi) begin
      hi_q   <= data_i;
      pend_q <= 1'b1;
    end else if (take_lo || sol_i) begin
      pend_q <= 1'b0;
    end
  end

  // low byte is left-justified on the bus
  assign done_o   = take_lo && pend_q && !sol_i;
  assign sample_o = {hi_q, data_i[BUS_W-1 -: LO_W]};
endmodule

// File: rtl/pix_chan_seq.sv
module pix_chan_seq
  import pix_reasm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned CH_W    = 2,
  parameter int unsigned LATENCY = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sol_i,
  input  logic                   adv_i,
  input  logic                   mode_i,
  input  logic [NUM_CH*CH_W-1:0] order_i,
  input  logic [CH_W-1:0]        fixed_ch_i,
  output logic [CH_W-1:0]        chan_o,
  output logic                   full_o
);
  localparam int unsigned POS_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned FILL_W = $clog2(LATENCY + 1);

  logic [POS_W-1:0]  pos_q;
  logic [FILL_W-1:0] fill_q;
  logic [CH_W-1:0]   slot_ch;

  always_comb begin
    slot_ch = order_i[CH_W-1:0];
    for (int i = 0; i < NUM_CH; i++) begin
      if (pos_q == POS_W'(i)) slot_ch = order_i[i*CH_W +: CH_W];
    end
  end

  assign chan_o = (ch_mode_e'(mode_i) == MODE_THREE) ? slot_ch : fixed_ch_i;
  assign full_o = (fill_q == FILL_W'(LATENCY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      fill_q <= '0;
    end else if (sol_i) begin
      pos_q  <= '0;
      fill_q <= '0;
    end else if (adv_i) begin
      if (!full_o) fill_q <= fill_q + 1'b1;
      if (ch_mode_e'(mode_i) == MODE_THREE) begin
        pos_q <= (pos_q == POS_W'(NUM_CH - 1)) ? '0 : pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_tag_delay.sv
module pix_tag_delay #(
  parameter int unsigned CH_W    = 2,
  parameter int unsigned LATENCY = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [CH_W-1:0] chan_i,
  output logic [CH_W-1:0] tag_o
);
  logic [CH_W-1:0] stage_q [LATENCY];

  for (genvar g = 0; g < LATENCY; g++) begin : g_stage
    logic [CH_W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = chan_i;
    end else begin : g_body
      assign nxt = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[g] <= '0;
      else if (clr_i) stage_q[g] <= '0;
      else if (adv_i) stage_q[g] <= nxt;
    end
  end

  assign tag_o = stage_q[LATENCY-1];
endmodule

// File: rtl/pix_reasm.sv
module pix_reasm #(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CH_W     = 2,
  parameter int unsigned LATENCY  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BUS_W-1:0]       data_i,
  input  logic                   phase_i,
  input  logic                   oe_i,
  input  logic                   sol_i,
  input  logic                   mode_i,
  input  logic [NUM_CH*CH_W-1:0] order_i,
  input  logic [CH_W-1:0]        fixed_ch_i,
  output logic [SAMPLE_W-1:0]    sample_o,
  output logic [CH_W-1:0]        chan_o,
  output logic                   valid_o
);
  logic                done;
  logic                full;
  logic [SAMPLE_W-1:0] joined;
  logic [CH_W-1:0]     cur_ch;
  logic [CH_W-1:0]     tag;

  pix_byte_join #(.BUS_W(BUS_W), .SAMPLE_W(SAMPLE_W)) i_join (
    .clk_i, .rst_ni, .data_i, .phase_i, .oe_i, .sol_i,
    .done_o(done), .sample_o(joined)
  );

  pix_chan_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .LATENCY(LATENCY)) i_seq (
    .clk_i, .rst_ni, .sol_i, .adv_i(done), .mode_i, .order_i, .fixed_ch_i,
    .chan_o(cur_ch), .full_o(full)
  );

  pix_tag_delay #(.CH_W(CH_W), .LATENCY(LATENCY)) i_tag (
    .clk_i, .rst_ni, .clr_i(sol_i), .adv_i(done), .chan_i(cur_ch), .tag_o(tag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      chan_o   <= '0;
    end else begin
      valid_o <= done && full;
      if (done && full) begin
        sample_o <= joined;
        chan_o   <= tag;
      end
    end
  end
endmodule

// File: rtl/pix_reasm_chk.sv
module pix_reasm_chk #(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned SAMPLE_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [BUS_W-1:0]    data_i,
  input logic                phase_i,
  input logic                oe_i,
  input logic                sol_i,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] sample_o
);
  localparam int unsigned LO_W = SAMPLE_W - BUS_W;

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_low_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o[LO_W-1:0] == $past(data_i[BUS_W-1 -: LO_W]));

  assert_low_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(oe_i && !phase_i));

  assert_oe_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (!valid_o && $stable(sample_o)));

  assert_sol_mute_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |=> !valid_o);
endmodule

bind pix_reasm pix_reasm_chk #(.BUS_W(BUS_W), .SAMPLE_W(SAMPLE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .phase_i(phase_i),
  .oe_i(oe_i), .sol_i(sol_i), .valid_o(valid_o), .sample_o(sample_o)
);

// File: tb/test_pix_reasm.sv
module test_pix_reasm;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        phase_i = 1'b0;
  logic        oe_i = 1'b0;
  logic        sol_i = 1'b0;
  logic        mode_i = 1'b1;
  logic [5:0]  order_i = 6'h24;
  logic [1:0]  fixed_ch_i = 2'd0;
  logic [13:0] sample_o;
  logic [1:0]  chan_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pix_reasm i_pix_reasm (
    .clk_i, .rst_ni, .data_i, .phase_i, .oe_i, .sol_i, .mode_i,
    .order_i, .fixed_ch_i, .sample_o, .chan_o, .valid_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_byte(input logic ph, input logic [7:0] b, input logic sol, input logic oe);
    @(negedge clk_i);
    phase_i = ph; data_i = b; sol_i = sol; oe_i = oe;
    @(posedge clk_i);
    #1;
    sol_i = 1'b0;
  endtask

  // one pixel; checks strobe, value and tag after the low byte
  task automatic send_pix(input logic [13:0] s, input logic [1:0] junk, input logic sol,
                          input bit exp_v, input logic [1:0] exp_ch, input string req);
    drive_byte(1'b1, s[13:6], sol, 1'b1);
    check(valid_o == 1'b0, "R4 no strobe on high byte", valid_o, 0);
    drive_byte(1'b0, {s[5:0], junk}, 1'b0, 1'b1);
    if (exp_v) begin
      check(valid_o == 1'b1, {req, " strobe"}, valid_o, 1);
      check(sample_o == s, {"R1 ", req, " sample"}, sample_o, s);
      check(chan_o == exp_ch, {req, " tag"}, chan_o, exp_ch);
    end else begin
      check(valid_o == 1'b0, {req, " suppressed"}, valid_o, 0);
    end
  endtask

  task automatic t_reset;
    check(valid_o == 1'b0, "R11 reset valid", valid_o, 0);
    check(sample_o == '0, "R11 reset sample", sample_o, 0);
    check(chan_o == '0, "R11 reset chan", chan_o, 0);
  endtask

  task automatic t_three(input logic [5:0] ord);
    mode_i = 1'b1; order_i = ord;
    for (int k = 0; k < 9; k++) begin
      logic [13:0] s;
      s = (k == 4) ? 14'h3FFF : (k == 5) ? 14'h0000 : 14'(14'h2A5 + k * 14'h0F3 + ord);
      send_pix(s, 2'(k), k == 0, k >= 3, ord[(k % 3) * 2 +: 2], "R6 R8 R9 three-channel");
    end
  endtask

  task automatic t_one(input logic [1:0] ch);
    mode_i = 1'b0; fixed_ch_i = ch; order_i = 6'h24;
    for (int k = 0; k < 6; k++) begin
      send_pix(14'(14'h1357 ^ (k * 14'h0421)), 2'b11, k == 0, k >= 3, ch, "R7 one-channel");
    end
  endtask

  task automatic t_latency;
    mode_i = 1'b0; fixed_ch_i = 2'd0;
    for (int k = 0; k < 8; k++) begin
      if (k == 4) fixed_ch_i = 2'd2;
      send_pix(14'(14'h0800 + k), 2'b01, k == 0, k >= 3, (k >= 7) ? 2'd2 : 2'd0,
               "R8 tag lag");
    end
  endtask

  task automatic t_oe_gap;
    mode_i = 1'b0; fixed_ch_i = 2'd1;
    for (int k = 0; k < 4; k++) send_pix(14'(14'h0100 + k), 2'b00, k == 0, k >= 3, 2'd1, "R5 warm");
    drive_byte(1'b1, 8'h48, 1'b0, 1'b1);            // high byte of 14'h1234
    drive_byte(1'b0, 8'hFF, 1'b0, 1'b0);
    check(valid_o == 1'b0, "R5 disabled low byte", valid_o, 0);
    drive_byte(1'b1, 8'h00, 1'b0, 1'b0);
    check(valid_o == 1'b0, "R5 disabled high byte", valid_o, 0);
    check(sample_o == 14'h0103, "R5 sample held", sample_o, 14'h0103);
    drive_byte(1'b0, {6'h34, 2'b10}, 1'b0, 1'b1);
    check(valid_o == 1'b1, "R5 strobe after gap", valid_o, 1);
    check(sample_o == 14'h1234, "R5 R2 joined across gap", sample_o, 14'h1234);
  endtask

  task automatic t_orphan;
    drive_byte(1'b0, 8'hA5, 1'b0, 1'b1);
    check(valid_o == 1'b0, "R3 orphan low byte", valid_o, 0);
    check(sample_o == 14'h1234, "R3 orphan leaves sample", sample_o, 14'h1234);
    drive_byte(1'b1, 8'h3C, 1'b0, 1'b1);
    check(valid_o == 1'b0, "R4 strobe gone", valid_o, 0);
    drive_byte(1'b0, 8'hC3, 1'b0, 1'b1);
    check(valid_o == 1'b1, "R3 normal after orphan", valid_o, 1);
    check(sample_o == 14'h0F30, "R3 R2 value", sample_o, 14'h0F30);
  endtask

  task automatic t_sol_collision;
    mode_i = 1'b1; order_i = 6'h09;
    for (int k = 0; k < 4; k++) send_pix(14'(14'h2000 + k), 2'b00, k == 0, k >= 3, order_i[(k % 3) * 2 +: 2], "R10 warm");
    drive_byte(1'b1, 8'hEE, 1'b0, 1'b1);
    drive_byte(1'b0, 8'h44, 1'b1, 1'b1);           // marker with low byte
    check(valid_o == 1'b0, "R10 collision dropped", valid_o, 0);
    check(sample_o == 14'h2003, "R10 sample held", sample_o, 14'h2003);
    for (int k = 0; k < 5; k++) send_pix(14'(14'h1A00 + k), 2'b10, 1'b0, k >= 3, order_i[(k % 3) * 2 +: 2], "R9 R10 restart");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_three(6'h24); t_three(6'h18); t_three(6'h21);
    t_three(6'h09); t_three(6'h12); t_three(6'h06);
    for (int c = 0; c < 3; c++) t_one(2'(c));
    t_latency();
    t_oe_gap();
    t_orphan();
    t_sol_collision();
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_run) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule